// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal sync, vertical sync and data-enable strobes for a raster display, along with the column and row of the pixel currently in the visible window. It runs on the pixel clock. A small register file, written one word at a time, holds the timing: four interval lengths for the horizontal axis, four for the vertical axis, a polarity word, a run control bit, and an interrupt mask and status pair. Each interval is written as its length minus one.

A line is made of four phases, always in the same order: sync pulse, back porch, visible data, front porch. The vertical counter goes through the same four phases and moves forward one step each time a line finishes. The front porch is the gap between the end of the visible data and the next sync pulse. The back porch is the gap between the end of sync and the start of the visible data. Writing 1 to the run bit starts the raster at the first cycle of a frame. Writing 0 stops it, holds both counters at zero and drives every strobe to its idle level.

Writes to timing and polarity while the raster runs are staged. They take effect together at the next frame boundary, so a line or frame is never built from a mix of old and new settings. A status flag is set each time a frame's vertical sync begins. The interrupt output is raised while both this flag and its mask bit are set. Software clears the flag by writing 1 to it.

Top module: `disp_timing_gen`

## Requirements
- R1: Each programmed interval value v gives a phase that lasts v+1 cycles (horizontal) or v+1 lines (vertical). A value of 0 gives a one-unit phase.
- R2: While running, each line cycles through sync, back porch, data and front porch in that order. The horizontal sync strobe is active exactly during the sync phase.
- R3: The vertical counter moves one step per completed line, through the same four phases in the same order. The vertical sync strobe is active for every cycle of the lines in its sync phase.
- R4: Data enable is active only when both axes are in their data phase. pix_x and pix_y give the zero-based offset inside the data phase of each axis and read 0 outside it.
- R5: Polarity word bit 0 is hsync, bit 1 is vsync, bit 2 is data enable; a 1 makes that strobe active-high and a 0 makes it active-low. Bit 3 is presented on data_pol in step with the strobes.
- R6: Control address 0, bit 0: writing 1 starts the raster, and the clock edge after the write is captured presents cycle 0 of a frame (both syncs active). Writing 0 stops it: from the second edge after capture the counters are zero and every strobe sits at its idle level.
- R7: The status bit (address 11, bit 0) is set when a frame's first cycle, the start of vertical sync, is presented. Writing 1 to it clears it. Writing 0 to it has no effect.
- R8: irq is high exactly when the status bit and the mask bit (address 10, bit 0) are both 1.
- R9: Interval and polarity writes made while running take effect at the next frame boundary. The frame in progress finishes with the old settings.
- R10: Register map: 0 control, 1 to 4 horizontal sync/back/data/front, 5 to 8 vertical sync/back/data/front, 9 polarity, 10 mask, 11 status. rd_data returns the programmed value at rd_addr one cycle after the address is presented.
- R11: After reset the raster is stopped, all intervals are 0, polarity is 4'b1111, mask and status are 0, and all strobes, positions and irq are 0 with data_pol at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write address |
| wr_data | input | DW | Register write data |
| rd_addr | input | AW | Register read address |
| rd_data | output | DW | Registered read data |
| hsync_o | output | 1 | Horizontal sync strobe |
| vsync_o | output | 1 | Vertical sync strobe |
| de_o | output | 1 | Data enable strobe |
| data_pol_o | output | 1 | Data polarity setting, aligned to the strobes |
| pix_x_o | output | CW | Column within the visible data |
| pix_y_o | output | CW | Row within the visible data |
| irq_o | output | 1 | Vertical sync interrupt |

## Verification
The reference model in the bench is driven by a fixed line-up of interval settings, compared every cycle. A layout with uneven phase lengths shows whether any phase is swapped or off by one. A setting with every interval at one unit checks the minus-one encoding at its lower bound and the phase transitions on consecutive cycles. Seeded random layouts with random polarity words catch combinations of lengths and strobe levels that the directed cases miss. A run in which the visible width and the polarity change part-way through a frame separates staged loading from immediate loading, because the mixed frame would have a different data-enable count. A masked run followed by clear writes of 0 and 1 separates the status flag from the interrupt pin.

// File: rtl/tg_pkg.sv
package tg_pkg;

  // Phase order within a line or a frame; the axis counter steps through
  // these in increasing code order and wraps from the last to the first.
  typedef enum logic [1:0] {
    PH_SYNC  = 2'd0,
    PH_BACK  = 2'd1,
    PH_ACT   = 2'd2,
    PH_FRONT = 2'd3
  } phase_e;

  localparam int unsigned NPH = 4;

  // Register addresses. Interval registers are laid out in phase order so
  // that base + phase code selects the right word.
  localparam int unsigned A_CTRL  = 0;
  localparam int unsigned A_HBASE = 1;
  localparam int unsigned A_VBASE = 5;
  localparam int unsigned A_POL   = 9;
  localparam int unsigned A_MASK  = 10;
  localparam int unsigned A_STAT  = 11;

  // Polarity word bit positions.
  localparam int unsigned PB_HS   = 0;
  localparam int unsigned PB_VS   = 1;
  localparam int unsigned PB_DE   = 2;
  localparam int unsigned PB_DATA = 3;
  localparam int unsigned PW      = 4;

endpackage

// File: rtl/tg_axis.sv
// One axis of the raster: a phase register and an in-phase counter.
module tg_axis
  import tg_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    run,
  input  logic                    step,
  input  logic [NPH-1:0][CW-1:0]  len,
  output phase_e                  ph,
  output logic [CW-1:0]           cnt,
  output logic                    last
);

  logic at_end;

  assign at_end = (cnt == len[ph]);
  assign last   = at_end && (ph == PH_FRONT);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      ph  <= PH_SYNC;
      cnt <= '0;
    end else if (step) begin
      if (at_end) begin
        cnt <= '0;
        ph  <= phase_e'(ph + 2'd1);
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R1: the in-phase count never passes the programmed length of its phase
  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (rst)
    cnt <= len[ph]);

  // R6: a stopped raster holds the counter at its origin
  assert_stop_origin_R6: assert property (@(posedge clk) disable iff (rst)
    !run |=> (ph == PH_SYNC && cnt == '0));

  // R2 (and R3 for the vertical instance): phases only advance in order
  assert_phase_order_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(run) && ph != $past(ph)) |-> (ph == phase_e'($past(ph) + 2'd1)));

endmodule

// File: rtl/tg_regs.sv
// Programmed registers, frame-boundary shadow copies and registered read port.
module tg_regs
  import tg_pkg::*;
#(
  parameter int CW = 12,
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [DW-1:0]           wr_data,
  input  logic [AW-1:0]           rd_addr,
  input  logic                    status_i,
  input  logic                    frame_load,
  output logic                    run,
  output logic [NPH-1:0][CW-1:0]  h_len,
  output logic [NPH-1:0][CW-1:0]  v_len,
  output logic [PW-1:0]           pol,
  output logic                    mask,
  output logic                    stat_clr,
  output logic [DW-1:0]           rd_data
);

  logic [NPH-1:0][CW-1:0] h_prog;
  logic [NPH-1:0][CW-1:0] v_prog;
  logic [PW-1:0]          pol_prog;
  logic [DW-1:0]          rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= 1'b0;
      h_prog   <= '0;
      v_prog   <= '0;
      pol_prog <= '1;
      mask     <= 1'b0;
    end else if (wr_en) begin
      if (int'(wr_addr) == A_CTRL) run      <= wr_data[0];
      if (int'(wr_addr) == A_POL)  pol_prog <= wr_data[PW-1:0];
      if (int'(wr_addr) == A_MASK) mask     <= wr_data[0];
      for (int i = 0; i < NPH; i++) begin
        if (int'(wr_addr) == A_HBASE + i) h_prog[i] <= wr_data[CW-1:0];
        if (int'(wr_addr) == A_VBASE + i) v_prog[i] <= wr_data[CW-1:0];
      end
    end
  end

  // Active copies follow the programmed words only at a frame boundary,
  // or continuously while the raster is stopped.
  always_ff @(posedge clk) begin
    if (rst) begin
      h_len <= '0;
      v_len <= '0;
      pol   <= '1;
    end else if (frame_load) begin
      h_len <= h_prog;
      v_len <= v_prog;
      pol   <= pol_prog;
    end
  end

  assign stat_clr = wr_en && (int'(wr_addr) == A_STAT) && wr_data[0];

  always_comb begin
    rd_mux = '0;
    if (int'(rd_addr) == A_CTRL) rd_mux[0]      = run;
    if (int'(rd_addr) == A_POL)  rd_mux[PW-1:0] = pol_prog;
    if (int'(rd_addr) == A_MASK) rd_mux[0]      = mask;
    if (int'(rd_addr) == A_STAT) rd_mux[0]      = status_i;
    for (int i = 0; i < NPH; i++) begin
      if (int'(rd_addr) == A_HBASE + i) rd_mux[CW-1:0] = h_prog[i];
      if (int'(rd_addr) == A_VBASE + i) rd_mux[CW-1:0] = v_prog[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end

  // R9: the active timing is frozen everywhere except at a frame boundary
  assert_shadow_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !frame_load |=> ($stable(h_len) && $stable(v_len) && $stable(pol)));

endmodule

// File: rtl/tg_irq.sv
// Vertical-sync status flag and masked interrupt.
module tg_irq (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic clr,
  input  logic mask,
  output logic status,
  output logic irq
);

  always_ff @(posedge clk) begin
    if (rst)          status <= 1'b0;
    else if (set_evt) status <= 1'b1;
    else if (clr)     status <= 1'b0;
  end

  assign irq = status & mask;

  // R7: a frame start always leaves the flag set
  assert_flag_set_R7: assert property (@(posedge clk) disable iff (rst)
    set_evt |=> status);

  // R7: a clear with no competing frame start empties the flag
  assert_flag_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (clr && !set_evt) |=> !status);

endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
  import tg_pkg::*;
#(
  parameter int CW = 12,
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic          data_pol_o,
  output logic [CW-1:0] pix_x_o,
  output logic [CW-1:0] pix_y_o,
  output logic          irq_o
);

  logic                   run;
  logic [NPH-1:0][CW-1:0] h_len;
  logic [NPH-1:0][CW-1:0] v_len;
  logic [PW-1:0]          pol;
  logic                   mask;
  logic                   stat_clr;
  logic                   status;

  phase_e          h_ph;
  phase_e          v_ph;
  logic [CW-1:0]   h_cnt;
  logic [CW-1:0]   v_cnt;
  logic            h_last;
  logic            v_last;
  logic            frame_load;
  logic            frame_start;
  logic            hs_act;
  logic            vs_act;
  logic            de_act;

  assign frame_load  = !run || (h_last && v_last);
  assign frame_start = run && (h_ph == PH_SYNC) && (h_cnt == '0)
                           && (v_ph == PH_SYNC) && (v_cnt == '0);

  tg_regs #(.CW(CW), .AW(AW), .DW(DW)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .status_i   (status),
    .frame_load (frame_load),
    .run        (run),
    .h_len      (h_len),
    .v_len      (v_len),
    .pol        (pol),
    .mask       (mask),
    .stat_clr   (stat_clr),
    .rd_data    (rd_data)
  );

  tg_axis #(.CW(CW)) u_hax (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .step (1'b1),
    .len  (h_len),
    .ph   (h_ph),
    .cnt  (h_cnt),
    .last (h_last)
  );

  tg_axis #(.CW(CW)) u_vax (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .step (h_last),
    .len  (v_len),
    .ph   (v_ph),
    .cnt  (v_cnt),
    .last (v_last)
  );

  tg_irq u_irq (
    .clk     (clk),
    .rst     (rst),
    .set_evt (frame_start),
    .clr     (stat_clr),
    .mask    (mask),
    .status  (status),
    .irq     (irq_o)
  );

  assign hs_act = run && (h_ph == PH_SYNC);
  assign vs_act = run && (v_ph == PH_SYNC);
  assign de_act = run && (h_ph == PH_ACT) && (v_ph == PH_ACT);

  // Output stage: one register, polarity applied on the way in.
  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_o    <= 1'b0;
      vsync_o    <= 1'b0;
      de_o       <= 1'b0;
      data_pol_o <= 1'b1;
      pix_x_o    <= '0;
      pix_y_o    <= '0;
    end else begin
      hsync_o    <= ~(hs_act ^ pol[PB_HS]);
      vsync_o    <= ~(vs_act ^ pol[PB_VS]);
      de_o       <= ~(de_act ^ pol[PB_DE]);
      data_pol_o <= pol[PB_DATA];
      pix_x_o    <= (run && h_ph == PH_ACT) ? h_cnt : '0;
      pix_y_o    <= (run && v_ph == PH_ACT) ? v_cnt : '0;
    end
  end

  // R4: a visible pixel is only ever flagged while the raster runs
  assert_de_needs_run_R4: assert property (@(posedge clk) disable iff (rst)
    (de_o == $past(pol[PB_DE]) && $past(pol[PB_DE]) == pol[PB_DE]
     && $past(pol[PB_DE]) == $past(pol[PB_DE], 2)) |-> $past(run));

endmodule

// File: tb/sim_disp_timing_gen.sv
`timescale 1ns/1ps
module sim_disp_timing_gen;
  localparam int CW = 12;
  localparam int AW = 4;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          hsync_o, vsync_o, de_o, data_pol_o, irq_o;
  logic [CW-1:0] pix_x_o, pix_y_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  int b_h[4], b_v[4];
  int b_pol = 15, b_mask = 0;
  int m_h[4], m_v[4];
  int m_pol;
  int mt = 0;
  bit chk_on = 0;
  event frame_ev;

  always #2 clk = ~clk;

  disp_timing_gen #(.CW(CW), .AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .hsync_o(hsync_o), .vsync_o(vsync_o),
    .de_o(de_o), .data_pol_o(data_pol_o), .pix_x_o(pix_x_o), .pix_y_o(pix_y_o),
    .irq_o(irq_o)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int phase_of(input int p, input int a0, input int a1, input int a2);
    if (p < a0) return 0;
    if (p < a0 + a1) return 1;
    if (p < a0 + a1 + a2) return 2;
    return 3;
  endfunction

  function automatic int flen();
    return (b_h[0] + b_h[1] + b_h[2] + b_h[3]) * (b_v[0] + b_v[1] + b_v[2] + b_v[3]);
  endfunction

  // Per-cycle reference model, built from the requirements only.
  always @(negedge clk) begin
    int ht, vt, line, hp, hph, vph, ex, ey, act;
    if (!chk_on) begin
      mt = 0; m_h = b_h; m_v = b_v; m_pol = b_pol;
    end else begin
      ht   = m_h[0] + m_h[1] + m_h[2] + m_h[3];
      vt   = m_v[0] + m_v[1] + m_v[2] + m_v[3];
      line = mt / ht;
      hp   = mt % ht;
      hph  = phase_of(hp, m_h[0], m_h[1], m_h[2]);
      vph  = phase_of(line, m_v[0], m_v[1], m_v[2]);
      ex   = (hph == 2) ? hp - m_h[0] - m_h[1] : 0;
      ey   = (vph == 2) ? line - m_v[0] - m_v[1] : 0;
      act  = (hph == 0) ? 1 : 0;
      check("R1 R2 hsync", int'(hsync_o), m_pol[0] ? act : 1 - act);
      act  = (vph == 0) ? 1 : 0;
      check("R1 R3 vsync", int'(vsync_o), m_pol[1] ? act : 1 - act);
      act  = (hph == 2 && vph == 2) ? 1 : 0;
      check("R4 R5 de", int'(de_o), m_pol[2] ? act : 1 - act);
      check("R1 R4 pix_x", int'(pix_x_o), ex);
      check("R1 R4 pix_y", int'(pix_y_o), ey);
      check("R5 data_pol", int'(data_pol_o), m_pol[3]);
      if (mt == 0) check("R7 R8 irq at frame start", int'(irq_o), b_mask);
      mt++;
      if (mt == ht * vt) begin
        mt = 0; m_h = b_h; m_v = b_v; m_pol = b_pol;
        -> frame_ev;
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = DW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    rd_addr = AW'(a);
    @(negedge clk);
    v = int'(rd_data);
  endtask

  task automatic program_cfg();
    for (int i = 0; i < 4; i++) begin
      wr(1 + i, b_h[i] - 1);
      wr(5 + i, b_v[i] - 1);
    end
    wr(9, b_pol);
    wr(10, b_mask);
  endtask

  task automatic start_run();
    wr(0, 1);
    #1 chk_on = 1;
  endtask

  task automatic stop_run();
    chk_on = 0;
    wr(0, 0);
    repeat (3) @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      check("R6 stopped hsync idle", int'(hsync_o), 1 - b_pol[0]);
      check("R6 stopped vsync idle", int'(vsync_o), 1 - b_pol[1]);
      check("R6 stopped de idle", int'(de_o), 1 - b_pol[2]);
      check("R6 stopped pix_x", int'(pix_x_o), 0);
      check("R6 stopped pix_y", int'(pix_y_o), 0);
      repeat (5) @(negedge clk);
    end
  endtask

  initial begin
    int v, cnt;
    void'($urandom(32'd24061));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11 reset state
    check("R11 hsync", int'(hsync_o), 0);
    check("R11 vsync", int'(vsync_o), 0);
    check("R11 de", int'(de_o), 0);
    check("R11 irq", int'(irq_o), 0);
    check("R11 pix_x", int'(pix_x_o), 0);
    check("R11 data_pol", int'(data_pol_o), 1);
    rd(9, v);  check("R11 polarity word", v, 15);
    rd(0, v);  check("R11 control", v, 0);
    rd(3, v);  check("R11 interval", v, 0);

    // Uneven phase lengths
    b_h = '{2, 3, 8, 2}; b_v = '{1, 2, 4, 1}; b_pol = 15; b_mask = 1;
    program_cfg();
    rd(3, v); check("R10 read h data", v, 7);
    rd(7, v); check("R10 read v data", v, 3);
    rd(9, v); check("R10 read polarity", v, 15);
    start_run();
    rd(0, v); check("R10 R6 read control", v, 1);
    repeat (2 * flen()) @(negedge clk);
    stop_run();

    // All intervals at one unit (R1 lower bound), mixed polarity
    b_h = '{1, 1, 1, 1}; b_v = '{1, 1, 1, 1}; b_pol = 4'b0101; b_mask = 1;
    program_cfg();
    start_run();
    repeat (3 * flen()) @(negedge clk);
    stop_run();

    // R9: mid-frame change of visible width and polarity
    b_h = '{2, 3, 8, 2}; b_v = '{1, 2, 4, 1}; b_pol = 15; b_mask = 1;
    program_cfg();
    start_run();
    repeat (10) @(negedge clk);
    b_h[2] = 5;  wr(3, 4);
    b_pol = 4'b1010; wr(9, 10);
    rd(3, v); check("R10 R9 programmed value readable at once", v, 4);
    @(frame_ev);
    cnt = 0;
    for (int k = 0; k < flen(); k++) begin
      @(negedge clk);
      if (de_o == 1'b0) cnt++;
    end
    check("R9 data-enable cycles in first frame after change", cnt, 5 * 4);
    repeat (flen()) @(negedge clk);
    stop_run();

    // R7 and R8: masked run, then flag handling while stopped
    b_h = '{2, 2, 4, 2}; b_v = '{1, 1, 3, 1}; b_pol = 15; b_mask = 0;
    program_cfg();
    wr(11, 1);
    start_run();
    repeat (flen() + 7) @(negedge clk);
    check("R8 irq held low by mask", int'(irq_o), 0);
    stop_run();
    rd(11, v); check("R7 status set by frame start", v, 1);
    wr(11, 0);
    rd(11, v); check("R7 write of 0 leaves status", v, 1);
    check("R8 irq low while masked", int'(irq_o), 0);
    wr(10, 1); b_mask = 1;
    check("R8 irq high when unmasked", int'(irq_o), 1);
    wr(11, 1);
    check("R8 irq low after clear", int'(irq_o), 0);
    rd(11, v); check("R7 status cleared by write of 1", v, 0);

    // Seeded random layouts
    for (int r = 0; r < 6; r++) begin
      for (int i = 0; i < 4; i++) begin
        b_h[i] = 1 + int'($urandom % 4);
        b_v[i] = 1 + int'($urandom % 3);
      end
      b_h[2] = 1 + int'($urandom % 12);
      b_v[2] = 1 + int'($urandom % 6);
      b_pol  = int'($urandom % 16);
      b_mask = 1;
      program_cfg();
      start_run();
      repeat (2 * flen()) @(negedge clk);
      stop_run();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule